// File: doc/BRIEF.md
# Two-Channel Edge-Selectable Input Capture

This block timestamps events on asynchronous input pins against a free-running counter that lives elsewhere. Each of the two channels brings its pin into the clock domain through a two-stage synchronizer. It then checks the synchronized level for the kind of transition that its mode field selects. When that transition is seen, the channel stores the counter value presented on `count_i` in its capture register and raises its event flag. Each flag can drive an interrupt line through its own enable.

Software, through a bus decoder outside this block, supplies a packed mode word with two bits per channel. It also supplies a per-channel interrupt enable and one clear strobe per flag, where a strobe bit at 1 clears that flag. Software reads the capture values and flags back from the output ports. The counter itself, register decoding and any bus logic sit outside this block.

Top module: `edge_capture_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every capture value, flag and interrupt output goes to 0.
- R2: Channel n takes its mode from bits [2n+1:2n] of `mode_i`. Channel 0 uses bits [1:0] and channel 1 uses bits [3:2].
- R3: Mode value 1 captures on low-to-high pin transitions only.
- R4: Mode value 2 captures on high-to-low pin transitions only.
- R5: Mode value 3 captures on both transition directions.
- R6: Mode value 0 performs no capture. The capture value and the flag keep their contents, and a set flag stays set.
- R7: A pin transition first sampled at rising edge k loads the capture register and sets the flag at edge k+2, not earlier. The stored value is the `count_i` value present at edge k+2.
- R8: A `flag_clr_i` bit at 1 on a rising edge clears that channel's flag. If a capture happens on the same edge, the flag stays set.
- R9: A qualifying edge overwrites the capture value even when the flag is already set, and the flag remains 1.
- R10: `irq_o[n]` equals `flag_o[n]` AND `irq_en_i[n]`, combinationally.
- R11: Pin activity, modes and clear strobes of one channel never change the other channel's capture value or flag.
- R12: The pin level history is tracked in every mode. A transition that happened while a channel was disabled is not captured when a capturing mode is selected later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the counter |
| rst_n | input | 1 | Synchronous reset, active low |
| count_i | input | 32 | Current value of the shared counter |
| pin_i | input | 2 | Asynchronous capture pins, one per channel |
| mode_i | input | 4 | Packed 2-bit capture modes, channel n at bits [2n+1:2n] |
| irq_en_i | input | 2 | Per-channel interrupt enable |
| flag_clr_i | input | 2 | Per-channel flag clear strobe, 1 clears |
| cap_o | output | 64 | Capture values, channel n at bits [32n+31:32n] |
| flag_o | output | 2 | Per-channel capture event flags |
| irq_o | output | 2 | Per-channel interrupt requests |

## Verification
The bench sweeps every mode on both channels with rising and falling transitions. It predicts each stored timestamp from the counter value at the expected capture edge. A design with the wrong synchronizer depth, or one that samples the counter one cycle off, stores the wrong timestamp. That design also fails the separate check that nothing changes one edge early. A design with swapped mode bits or a shifted field stride fires on the wrong direction or on the wrong channel, and the check of the idle channel reports it. The bench also raises a clear strobe on the same edge as a capture, where a design giving the clear priority would lose the event. Finally, it moves a pin while the channel is disabled and then enables the channel, where a design that freezes its edge history would report a capture that never happened.

// File: rtl/cap_pkg.sv
// Package: shared types for the input capture unit.
// Holds the per-channel mode encoding; the numeric values are part of the
// programming interface and must not be reordered.
package cap_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        CAP_OFF  = 2'd0,
        CAP_RISE = 2'd1,
        CAP_FALL = 2'd2,
        CAP_BOTH = 2'd3
    } cap_mode_e;

endpackage

// File: rtl/cap_sync.sv
// Module: cap_sync
// Multi-stage synchronizer that brings one asynchronous level into the clk
// domain. Assumes STAGES >= 2 and that the input is a slow level signal, so
// a pulse narrower than one clock may be missed. Resets to low.
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/cap_edge_det.sv
// Module: cap_edge_det
// Keeps a one-cycle history of the synchronized level and flags the
// transitions the current mode asks for. The history register updates in
// every mode, so enabling a channel never produces a stale edge.
module cap_edge_det
    import cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level_i,
    input  cap_mode_e mode_i,
    output logic      hit_o
);

    logic prev_q;
    logic rise;
    logic fall;

    // Remember last cycle's level regardless of mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level_i;
        end
    end

    assign rise = level_i & ~prev_q;
    assign fall = ~level_i & prev_q;

    // Select the qualifying transition for the programmed mode.
    always_comb begin
        unique case (mode_i)
            CAP_OFF:  hit_o = 1'b0;
            CAP_RISE: hit_o = rise;
            CAP_FALL: hit_o = fall;
            CAP_BOTH: hit_o = rise | fall;
            default:  hit_o = 1'b0;
        endcase
    end

    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CAP_OFF) |-> !hit_o); // R6
    AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (level_i != $past(level_i))); // R5
    AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && mode_i == CAP_RISE) |-> level_i); // R3
    AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && mode_i == CAP_FALL) |-> !level_i); // R4

endmodule

// File: rtl/cap_channel.sv
// Module: cap_channel
// One capture channel: synchronizer, edge qualifier, timestamp register and
// event flag. Assumes count_i is synchronous to clk. A new capture always
// overwrites the timestamp; a capture beats a clear on the same edge.
module cap_channel
    import cap_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  cap_mode_e        mode_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             clr_i,
    input  logic             irq_en_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             flag_o,
    output logic             irq_o
);

    logic             pin_sync;
    logic             hit;
    logic [CNT_W-1:0] cap_q;
    logic             flag_q;

    cap_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    cap_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pin_sync),
        .mode_i  (mode_i),
        .hit_o   (hit)
    );

    // Latch the counter on every qualifying edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (hit) begin
            cap_q <= count_i;
        end
    end

    // Set the flag on capture, otherwise honour the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign cap_o  = cap_q;
    assign flag_o = flag_q;
    assign irq_o  = flag_q & irq_en_i;

    AST_CAP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cap_o == $past(count_i))); // R7
    AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cap_o)); // R6
    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_o); // R8
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !flag_o); // R8
    AST_FLAG_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(hit)); // R9
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_o && irq_en_i)); // R10

endmodule

// File: rtl/edge_capture_unit.sv
// Module: edge_capture_unit
// Top of the input capture unit: NUM_CH independent channels sharing one
// counter input. Mode fields are packed at a MODE_W-bit stride, channel n at
// bits [MODE_W*n +: MODE_W]; capture values are packed at a CNT_W stride.
// Assumes the counter and all strobes are synchronous to clk.
module edge_capture_unit
    import cap_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT_W-1:0]          count_i,
    input  logic [NUM_CH-1:0]         pin_i,
    input  logic [NUM_CH*MODE_W-1:0]  mode_i,
    input  logic [NUM_CH-1:0]         irq_en_i,
    input  logic [NUM_CH-1:0]         flag_clr_i,
    output logic [NUM_CH*CNT_W-1:0]   cap_o,
    output logic [NUM_CH-1:0]         flag_o,
    output logic [NUM_CH-1:0]         irq_o
);

    localparam int CAP_BITS = NUM_CH * CNT_W;

    logic [CAP_BITS-1:0] cap_all;

    // One channel per pin, each decoding its own slice of the mode word.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cap_mode_e ch_mode;
        assign ch_mode = cap_mode_e'(mode_i[g*MODE_W +: MODE_W]);

        cap_channel #(
            .CNT_W       (CNT_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (pin_i[g]),
            .mode_i   (ch_mode),
            .count_i  (count_i),
            .clr_i    (flag_clr_i[g]),
            .irq_en_i (irq_en_i[g]),
            .cap_o    (cap_all[g*CNT_W +: CNT_W]),
            .flag_o   (flag_o[g]),
            .irq_o    (irq_o[g])
        );
    end

    assign cap_o = cap_all;

    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (flag_o == '0 && cap_o == '0)); // R1

endmodule

// File: tb/edge_capture_unit_tb.sv
module edge_capture_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int CW  = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [CW-1:0]      count_i = 32'h0000_0100;
    logic [NCH-1:0]     pin = '0;
    logic [2*NCH-1:0]   mode = '0;
    logic [NCH-1:0]     ien = '0;
    logic [NCH-1:0]     clr = '0;
    logic [NCH*CW-1:0]  cap;
    logic [NCH-1:0]     flag;
    logic [NCH-1:0]     irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [CW-1:0] exp_cap [NCH];
    logic          exp_flag [NCH];

    edge_capture_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_i    (count_i),
        .pin_i      (pin),
        .mode_i     (mode),
        .irq_en_i   (ien),
        .flag_clr_i (clr),
        .cap_o      (cap),
        .flag_o     (flag),
        .irq_o      (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Counter changes only at falling edges, so it is stable at each capture.
    always @(negedge clk) count_i <= count_i + 32'h0001_0007;

    task automatic chk(input logic [CW-1:0] act, input logic [CW-1:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int c = 0; c < NCH; c++) begin
            chk(cap[c*CW +: CW], exp_cap[c], $sformatf("%s ch%0d capture", req, c));
            chk({31'b0, flag[c]}, {31'b0, exp_flag[c]}, $sformatf("%s R11 ch%0d flag", req, c));
            chk({31'b0, irq[c]}, {31'b0, exp_flag[c] & ien[c]}, $sformatf("R10 ch%0d irq", c));
        end
    endtask

    // Move one pin and check both channels at the third rising edge.
    task automatic drive_pin(input int c, input logic lvl, input string req);
        logic [1:0] m;
        logic q;
        @(negedge clk);
        m = mode[2*c +: 2];
        q = (lvl != pin[c]) &&
            ((m == 2'd3) || (m == 2'd1 && lvl) || (m == 2'd2 && !lvl));
        pin[c] = lvl;
        repeat (3) @(posedge clk);
        #1;
        if (q) begin
            exp_cap[c]  = count_i;
            exp_flag[c] = 1'b1;
        end
        chk_all(req);
    endtask

    task automatic clear_flags(input logic [NCH-1:0] mask, input string req);
        @(negedge clk);
        clr = mask;
        @(negedge clk);
        clr = '0;
        for (int c = 0; c < NCH; c++) if (mask[c]) exp_flag[c] = 1'b0;
        chk_all(req);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        string tag;
        logic [CW-1:0] old_cap;
        for (int c = 0; c < NCH; c++) begin
            exp_cap[c]  = '0;
            exp_flag[c] = 1'b0;
        end
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk_all("R1");

        // R2-R5, R11: every capturing mode, both directions, both channels
        for (int c = 0; c < NCH; c++) begin
            for (int m = 1; m < 4; m++) begin
                tag = (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
                @(negedge clk);
                mode = '0;
                mode[2*c +: 2] = 2'(m);
                mode[2*(1-c) +: 2] = 2'(4 - m);
                ien = 2'(m);
                clear_flags(2'b11, "R8");
                drive_pin(c, 1'b1, {tag, " R2"});
                drive_pin(c, 1'b0, {tag, " R2"});
                drive_pin(c, 1'b1, {tag, " R2"});
                drive_pin(c, 1'b0, {tag, " R2"});
            end
        end

        // R6: disabled channel keeps its value and its set flag
        @(negedge clk);
        mode = 4'b0011;
        ien  = 2'b11;
        drive_pin(0, 1'b1, "R5");
        @(negedge clk);
        mode = 4'b0000;
        drive_pin(0, 1'b0, "R6");
        drive_pin(0, 1'b1, "R6");
        clear_flags(2'b01, "R6 R8");
        drive_pin(0, 1'b0, "R6");

        // R9: overwrite while flag is still set
        @(negedge clk);
        mode = 4'b0100;
        drive_pin(1, 1'b1, "R9");
        drive_pin(1, 1'b0, "R9");
        old_cap = exp_cap[1];
        drive_pin(1, 1'b1, "R9");
        chk({31'b0, (cap[CW +: CW] != old_cap)}, 32'd1, "R9 value replaced");

        // R7: nothing changes at the second edge, capture at the third
        @(negedge clk);
        mode = 4'b1100;
        clear_flags(2'b10, "R8");
        @(negedge clk);
        pin[1] = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk_all("R7 early");
        @(posedge clk);
        #1;
        exp_cap[1]  = count_i;
        exp_flag[1] = 1'b1;
        chk_all("R7");

        // R8: clear strobe on the same edge as a capture loses to the set
        clear_flags(2'b10, "R8");
        @(negedge clk);
        pin[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        clr = 2'b10;
        @(posedge clk);
        #1;
        exp_cap[1]  = count_i;
        exp_flag[1] = 1'b1;
        chk_all("R8 set wins");
        @(negedge clk);
        clr = '0;

        // R12: a transition made while disabled is not seen after enabling
        @(negedge clk);
        mode = 4'b0000;
        clear_flags(2'b11, "R8");
        drive_pin(0, 1'b1, "R12 disabled");
        @(negedge clk);
        mode = 4'b0001;
        repeat (4) @(posedge clk);
        #1;
        chk_all("R12 after enable");
        drive_pin(0, 1'b0, "R12");
        drive_pin(0, 1'b1, "R12");

        // R10: interrupt gating under every enable pattern
        for (int e = 0; e < 4; e++) begin
            @(negedge clk);
            ien = 2'(e);
            #1;
            chk_all("R10");
        end

        summary();
        $finish;
    end

endmodule